// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block owns the control lines and divider buses of an integer/fractional PLL and performs its power-up, power-down and rate-change procedures in hardware. It takes the place of a timed software routine. Software writes the requested divider settings into staging registers through a small write port. It then issues a command. The block walks the PLL through the required steps, times the reset hold in microseconds, waits for lock with a bounded timeout, and reports the outcome.

A rate change first compares the staged multiplier and pre-divider with the ones the PLL is running.

- When both match, only the post-divider and the fractional value are updated. This happens in the cycle the command is accepted, with no reset and no bypass.
- Otherwise the PLL is taken offline and reprogrammed. Bypass stays on until the synchronized lock input confirms the new frequency.

Microsecond timing comes from a prescaler set by a cycles-per-microsecond parameter. The analog PLL, the choice of divider values and any frequency arithmetic are outside this block.

Top module: `pll_seq_ctrl`

## Requirements
- R1: Out of reset, `pll_rst_n`, `pll_bypass`, `pll_lock_sel`, `busy`, `done`, `fail` and `err` are all 0. The divider outputs hold the parameter defaults (DEF_MDIV, DEF_PDIV, DEF_SDIV, DEF_KDIV).
- R2: The write port decodes `wr_sel` as follows:
  - 0 loads the staging divider word, with the multiplier in bits 21:12, the pre-divider in bits 9:4 and the post-divider in bits 2:0.
  - 1 loads the staging fractional value from bits 15:0.
  - 2 issues a command from bits 2:0. Bit 0 is rate change, bit 1 is power-up and bit 2 is power-down, with priority in that order.
  - 3 has no effect.
  - A command word with bits 2:0 all zero has no effect.
- R3: A rate change whose staged multiplier and pre-divider equal the current outputs updates only `pll_sdiv` and `pll_kdiv`. It raises `done` in the cycle after acceptance and leaves `pll_rst_n`, `pll_bypass` and `busy` untouched.
- R4: Any other rate change sets `pll_lock_sel`, then drops `pll_rst_n`, then raises `pll_bypass`, then drives all four divider buses, each in a later cycle than the one before.
- R5: After the dividers change, `pll_rst_n` stays low for at least RST_HOLD_US × CYC_PER_US cycles before it rises.
- R6: `pll_lock` passes through a two-flop synchronizer. `pll_bypass` falls only after a synchronized lock, and a one-cycle `done` pulse marks success.
- R7: If no lock is seen within LOCK_TMO_US microseconds of the reset release, the sequence ends with a one-cycle `fail` pulse. `err` is then set, and `pll_bypass` and `pll_rst_n` stay high.
- R8: Power-up with `pll_rst_n` already high only pulses `done`. With `pll_rst_n` low, it raises bypass, then releases reset, then waits for lock and clears bypass.
- R9: Power-down drives `pll_rst_n` low and pulses `done` in the cycle after acceptance.
- R10: While `busy` is high, every write, whether staging or command, is ignored.
- R11: `err` stays set until the next accepted command, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: divider, fraction, command |
| wr_data | input | 32 | Write data |
| pll_lock | input | 1 | Raw lock indication from the PLL |
| pll_rst_n | output | 1 | PLL reset, low holds it in power-down |
| pll_bypass | output | 1 | Route reference clock around the PLL |
| pll_lock_sel | output | 1 | Lock source select, set on first relock |
| pll_mdiv | output | MDIV_W | Main multiplier |
| pll_pdiv | output | PDIV_W | Pre-divider |
| pll_sdiv | output | SDIV_W | Post-divider shift |
| pll_kdiv | output | KDIV_W | Fractional value |
| busy | output | 1 | A multi-cycle sequence is running |
| done | output | 1 | One-cycle success pulse |
| fail | output | 1 | One-cycle lock timeout pulse |
| err | output | 1 | Sticky timeout flag |

## Verification
The assertions assume that the lock input falls while the PLL is held in reset, so a stale lock cannot end a new wait. They also assume that the lock input never rises during the program and hold steps. The bench's lock stub enforces both: it clears its lock whenever `pll_rst_n` is low, and it raises lock only after a random delay that is shorter than the timeout, or never in the timeout scenario. Random divider values are drawn so that each full change really differs in multiplier or pre-divider, and each short change reuses the current pair.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RST,
      S_BYP,
      S_PROG,
      S_HOLD,
      S_REL,
      S_LOCK
   } seq_state_t;

   localparam logic [1:0] SEL_DIV  = 2'd0;
   localparam logic [1:0] SEL_FRAC = 2'd1;
   localparam logic [1:0] SEL_CMD  = 2'd2;

   localparam int CMD_RATE = 0;
   localparam int CMD_UP   = 1;
   localparam int CMD_DOWN = 2;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pll_lock_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
   parameter int CYC_PER_US = 125,
   parameter int MAX_US     = 10000,
   localparam int PRE_W     = $clog2(CYC_PER_US),
   localparam int CNT_W     = $clog2(MAX_US + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] us_cnt
);

   logic [PRE_W-1:0] pre;

   generate
      if (CYC_PER_US < 2) begin : g_bad_cyc
         $error("CYC_PER_US must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre    <= '0;
         us_cnt <= '0;
      end else if (!run) begin
         pre    <= '0;
         us_cnt <= '0;
      end else if (pre == PRE_W'(CYC_PER_US - 1)) begin
         pre <= '0;
         if (us_cnt != CNT_W'(MAX_US)) us_cnt <= us_cnt + 1'b1;
      end else begin
         pre <= pre + 1'b1;
      end
   end

   // a fresh run window always starts from zero elapsed microseconds
   p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (us_cnt == '0));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
   import pll_seq_pkg::*;
#(
   parameter int CYC_PER_US  = 125,
   parameter int RST_HOLD_US = 3,
   parameter int LOCK_TMO_US = 10000,
   parameter int MDIV_W      = 10,
   parameter int PDIV_W      = 6,
   parameter int SDIV_W      = 3,
   parameter int KDIV_W      = 16,
   parameter bit FRAC_EN     = 1'b1,
   parameter int DEF_MDIV    = 250,
   parameter int DEF_PDIV    = 3,
   parameter int DEF_SDIV    = 1,
   parameter int DEF_KDIV    = 0,
   localparam int DATA_W     = 32,
   localparam int M_LSB      = 12,
   localparam int P_LSB      = 4,
   localparam int S_LSB      = 0,
   localparam int MAX_US     = (RST_HOLD_US > LOCK_TMO_US) ? RST_HOLD_US : LOCK_TMO_US,
   localparam int CNT_W      = $clog2(MAX_US + 1),
   localparam int HOLD_CYC   = RST_HOLD_US * CYC_PER_US,
   localparam int HC_W       = $clog2(HOLD_CYC + 2) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pll_lock,
   output logic              pll_rst_n,
   output logic              pll_bypass,
   output logic              pll_lock_sel,
   output logic [MDIV_W-1:0] pll_mdiv,
   output logic [PDIV_W-1:0] pll_pdiv,
   output logic [SDIV_W-1:0] pll_sdiv,
   output logic [KDIV_W-1:0] pll_kdiv,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              err
);

   generate
      if (M_LSB + MDIV_W > DATA_W) begin : g_bad_m
         $error("multiplier field exceeds data word");
      end
      if (P_LSB + PDIV_W > M_LSB) begin : g_bad_p
         $error("pre-divider field overlaps multiplier");
      end
      if (S_LSB + SDIV_W > P_LSB) begin : g_bad_s
         $error("post-divider field overlaps pre-divider");
      end
      if (KDIV_W > DATA_W) begin : g_bad_k
         $error("fraction wider than data word");
      end
      if (RST_HOLD_US < 1 || LOCK_TMO_US < 1) begin : g_bad_t
         $error("hold and timeout must be at least one microsecond");
      end
   endgenerate

   seq_state_t         state;
   logic               lock_s;
   logic               tmr_run;
   logic [CNT_W-1:0]   us_cnt;
   logic [MDIV_W-1:0]  stg_m;
   logic [PDIV_W-1:0]  stg_p;
   logic [SDIV_W-1:0]  stg_s;
   logic [KDIV_W-1:0]  stg_k;
   logic               idle_wr;
   logic [2:0]         cmd;

   assign busy    = (state != S_IDLE);
   assign idle_wr = wr_en && (state == S_IDLE);
   assign cmd     = wr_data[2:0];
   assign tmr_run = (state == S_HOLD) || (state == S_LOCK);

   pll_lock_sync #(.STAGES(2)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(pll_lock),
      .q_sync (lock_s)
   );

   pll_us_timer #(.CYC_PER_US(CYC_PER_US), .MAX_US(MAX_US)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tmr_run),
      .us_cnt(us_cnt)
   );

   // staging of integer dividers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_m <= MDIV_W'(DEF_MDIV);
         stg_p <= PDIV_W'(DEF_PDIV);
         stg_s <= SDIV_W'(DEF_SDIV);
      end else if (idle_wr && wr_sel == SEL_DIV) begin
         stg_m <= wr_data[M_LSB +: MDIV_W];
         stg_p <= wr_data[P_LSB +: PDIV_W];
         stg_s <= wr_data[S_LSB +: SDIV_W];
      end
   end

   // fractional staging exists only on the fractional variant
   generate
      if (FRAC_EN) begin : g_frac
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              stg_k <= KDIV_W'(DEF_KDIV);
            else if (idle_wr && wr_sel == SEL_FRAC) stg_k <= wr_data[KDIV_W-1:0];
         end
      end else begin : g_int
         assign stg_k = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= S_IDLE;
         pll_rst_n    <= 1'b0;
         pll_bypass   <= 1'b0;
         pll_lock_sel <= 1'b0;
         pll_mdiv     <= MDIV_W'(DEF_MDIV);
         pll_pdiv     <= PDIV_W'(DEF_PDIV);
         pll_sdiv     <= SDIV_W'(DEF_SDIV);
         pll_kdiv     <= FRAC_EN ? KDIV_W'(DEF_KDIV) : '0;
         done         <= 1'b0;
         fail         <= 1'b0;
         err          <= 1'b0;
      end else begin
         done <= 1'b0;
         fail <= 1'b0;
         case (state)
            S_IDLE: begin
               if (idle_wr && wr_sel == SEL_CMD && cmd != 3'b000) begin
                  err <= 1'b0;
                  if (cmd[CMD_RATE]) begin
                     if (stg_m == pll_mdiv && stg_p == pll_pdiv) begin
                        pll_sdiv <= stg_s;
                        pll_kdiv <= stg_k;
                        done     <= 1'b1;
                     end else begin
                        pll_lock_sel <= 1'b1;
                        state        <= S_RST;
                     end
                  end else if (cmd[CMD_UP]) begin
                     if (pll_rst_n) begin
                        done <= 1'b1;
                     end else begin
                        pll_bypass <= 1'b1;
                        state      <= S_REL;
                     end
                  end else begin
                     pll_rst_n <= 1'b0;
                     done      <= 1'b1;
                  end
               end
            end
            S_RST: begin
               pll_rst_n <= 1'b0;
               state     <= S_BYP;
            end
            S_BYP: begin
               pll_bypass <= 1'b1;
               state      <= S_PROG;
            end
            S_PROG: begin
               pll_mdiv <= stg_m;
               pll_pdiv <= stg_p;
               pll_sdiv <= stg_s;
               pll_kdiv <= stg_k;
               state    <= S_HOLD;
            end
            S_HOLD: begin
               if (us_cnt >= CNT_W'(RST_HOLD_US)) state <= S_REL;
            end
            S_REL: begin
               pll_rst_n <= 1'b1;
               state     <= S_LOCK;
            end
            S_LOCK: begin
               if (lock_s) begin
                  pll_bypass <= 1'b0;
                  done       <= 1'b1;
                  state      <= S_IDLE;
               end else if (us_cnt >= CNT_W'(LOCK_TMO_US)) begin
                  fail  <= 1'b1;
                  err   <= 1'b1;
                  state <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // cycles since the dividers were last programmed, saturating
   logic [HC_W-1:0] chk_hold;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                chk_hold <= '0;
      else if (state == S_PROG)                  chk_hold <= '0;
      else if (chk_hold <= HC_W'(HOLD_CYC))      chk_hold <= chk_hold + 1'b1;
   end

   p_hold_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_REL && $past(state) == S_HOLD) |-> (chk_hold >= HC_W'(HOLD_CYC)));

   p_bypass_at_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_rst_n) |-> pll_bypass);

   p_unbypass_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_bypass) |-> $past(lock_s));

   p_mdiv_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pll_mdiv) |-> (!pll_rst_n && pll_bypass));

   p_done_fail_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   p_fail_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> (err && pll_bypass && pll_rst_n));

   p_busy_holds_stage_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(busy) |-> $stable(stg_m));

endmodule

// File: tb/sim_pll_seq_ctrl.sv
module sim_pll_seq_ctrl;
   localparam int CYC  = 4;
   localparam int HOLD = 3;
   localparam int TMO  = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic        lock = 1'b0;
   logic        pll_rst_n, pll_bypass, pll_lock_sel, busy, done, fail, err;
   logic [9:0]  pll_mdiv;
   logic [5:0]  pll_pdiv;
   logic [2:0]  pll_sdiv;
   logic [15:0] pll_kdiv;

   pll_seq_ctrl #(.CYC_PER_US(CYC), .RST_HOLD_US(HOLD), .LOCK_TMO_US(TMO)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pll_lock(lock), .pll_rst_n(pll_rst_n), .pll_bypass(pll_bypass),
      .pll_lock_sel(pll_lock_sel), .pll_mdiv(pll_mdiv), .pll_pdiv(pll_pdiv),
      .pll_sdiv(pll_sdiv), .pll_kdiv(pll_kdiv), .busy(busy), .done(done),
      .fail(fail), .err(err));

   // lock stub: lock drops in reset, rises lock_dly cycles after release
   int lock_dly = 5;
   bit never = 1'b0;
   int lcnt = 0;
   always @(posedge clk) begin
      if (!pll_rst_n) begin
         lcnt <= 0;
         lock <= 1'b0;
      end else if (!never) begin
         if (lcnt >= lock_dly) lock <= 1'b1;
         else                  lcnt <= lcnt + 1;
      end
   end

   int n_chk = 0, n_bad = 0;
   bit ended = 1'b0;
   int em = 250, ep = 3, es = 1, ek = 0;
   int t_lsel, t_rstfall, t_byprise, t_div, t_rstrise, t_bypfall, t_end;
   bit sd, sf;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] divword(input int m, input int p, input int s);
      return (32'(m & 10'h3ff) << 12) | (32'(p & 6'h3f) << 4) | 32'(s & 3'h7);
   endfunction

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic stage(input int m, input int p, input int s, input int k);
      wr(2'd0, divword(m, p, s));
      wr(2'd1, 32'(k & 16'hffff));
   endtask

   task automatic run_cmd(input logic [2:0] cmd, input int inj_n);
      logic p_rst, p_byp, p_ls;
      logic [9:0] p_m;
      logic [5:0] p_p;
      int n;
      p_rst = pll_rst_n; p_byp = pll_bypass; p_ls = pll_lock_sel;
      p_m = pll_mdiv; p_p = pll_pdiv;
      t_lsel = -1; t_rstfall = -1; t_byprise = -1; t_div = -1;
      t_rstrise = -1; t_bypfall = -1;
      sd = 1'b0; sf = 1'b0;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = {29'd0, cmd};
      @(negedge clk);
      wr_en = 1'b0;
      n = 0;
      while (n < 3000) begin
         if (pll_lock_sel && !p_ls)        t_lsel = n;
         if (!pll_rst_n && p_rst)          t_rstfall = n;
         if (pll_rst_n && !p_rst)          t_rstrise = n;
         if (pll_bypass && !p_byp)         t_byprise = n;
         if (!pll_bypass && p_byp)         t_bypfall = n;
         if (pll_mdiv != p_m || pll_pdiv != p_p) t_div = n;
         p_rst = pll_rst_n; p_byp = pll_bypass; p_ls = pll_lock_sel;
         p_m = pll_mdiv; p_p = pll_pdiv;
         if (done) sd = 1'b1;
         if (fail) sf = 1'b1;
         if (sd || sf || !busy) break;
         if (n == inj_n) begin
            wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'd4;
         end else if (n == inj_n + 1) begin
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = divword(5, 5, 5);
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      wr_en = 1'b0;
      t_end = n;
   endtask

   task automatic check_outs(input string req);
      check(pll_mdiv == 10'(em), req, "mdiv", pll_mdiv, em);
      check(pll_pdiv == 6'(ep),  req, "pdiv", pll_pdiv, ep);
      check(pll_sdiv == 3'(es),  req, "sdiv", pll_sdiv, es);
      check(pll_kdiv == 16'(ek), req, "kdiv", pll_kdiv, ek);
   endtask

   task automatic full_change(input int inj_n);
      int m, p;
      m = em; p = ep;
      while (m == em && p == ep) begin
         m = 1 + ($urandom % 1023);
         p = 1 + ($urandom % 63);
      end
      em = m; ep = p; es = $urandom % 8; ek = $urandom % 65536;
      lock_dly = $urandom % 31;
      stage(em, ep, es, ek);
      run_cmd(3'b001, inj_n);
      check(sd && !sf, "R6", "rate change completes", sd, 1);
      check(t_lsel == -1 || t_lsel < t_rstfall, "R4", "lock select before reset", t_lsel, t_rstfall);
      check(t_rstfall >= 0 && t_rstfall < t_byprise, "R4", "reset before bypass", t_rstfall, t_byprise);
      check(t_byprise < t_div, "R4", "bypass before dividers", t_byprise, t_div);
      check(t_rstrise - t_div >= HOLD * CYC, "R5", "reset hold cycles", t_rstrise - t_div, HOLD * CYC);
      check(t_bypfall - t_rstrise >= lock_dly + 3, "R6", "unbypass after synced lock",
            t_bypfall - t_rstrise, lock_dly + 3);
      check(pll_rst_n && !pll_bypass && pll_lock_sel, "R6", "final control lines",
            {pll_rst_n, pll_bypass, pll_lock_sel}, 3'b101);
      check_outs("R4");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check({pll_rst_n, pll_bypass, pll_lock_sel, busy, done, fail, err} == 7'd0,
            "R1", "control and status", {pll_rst_n, pll_bypass, pll_lock_sel, busy, done, fail, err}, 0);
      check_outs("R1");

      // R8 power-up from reset
      lock_dly = 4;
      run_cmd(3'b010, -10);
      check(sd && pll_rst_n && !pll_bypass, "R8", "power-up result", {sd, pll_rst_n, pll_bypass}, 3'b110);
      check(t_byprise >= 0 && t_byprise < t_rstrise && t_rstrise < t_bypfall, "R8",
            "bypass, release, unbypass order", t_rstrise, t_byprise + 1);
      @(negedge clk);
      check(!done, "R6", "done is a single-cycle pulse", done, 0);

      // R8 power-up while running
      run_cmd(3'b010, -10);
      check(sd && t_end == 0 && t_byprise == -1, "R8", "already running", t_end, 0);

      // R3 short changes, R2 field positions
      for (int i = 0; i < 8; i++) begin
         es = $urandom % 8; ek = $urandom % 65536;
         stage(em, ep, es, ek);
         run_cmd(3'b001, -10);
         check(sd && t_end == 0, "R3", "immediate done", t_end, 0);
         check(t_rstfall == -1 && t_byprise == -1 && pll_rst_n && !pll_bypass, "R3",
               "no reset or bypass", t_rstfall, -1);
         check_outs("R3");
      end

      // R4 R5 R6 full changes
      for (int i = 0; i < 6; i++) full_change(-10);

      // R10 writes while busy are ignored
      full_change(3);
      check(pll_rst_n == 1'b1, "R10", "power-down while busy ignored", pll_rst_n, 1);
      run_cmd(3'b001, -10);
      check(sd && t_end == 0, "R10", "staging write while busy ignored", t_end, 0);
      check_outs("R10");

      // R7 lock timeout
      never = 1'b1;
      em = (em % 1000) + 3; es = $urandom % 8; ek = $urandom % 65536;
      stage(em, ep, es, ek);
      run_cmd(3'b001, -10);
      check(sf && !sd, "R7", "fail pulse", sf, 1);
      check(err && pll_bypass && pll_rst_n, "R7", "err, bypass, reset released",
            {err, pll_bypass, pll_rst_n}, 3'b111);
      check(t_end - t_rstrise >= TMO * CYC && t_end - t_rstrise <= TMO * CYC + 4, "R7",
            "timeout length", t_end - t_rstrise, TMO * CYC);
      check_outs("R7");
      repeat (10) @(negedge clk);
      check(err == 1'b1 && !fail, "R11", "err sticky", err, 1);
      never = 1'b0;

      // R9 power-down, R11 err cleared
      run_cmd(3'b100, -10);
      check(sd && t_end == 0 && !pll_rst_n, "R9", "power-down", pll_rst_n, 0);
      check(!err, "R11", "err cleared by command", err, 0);

      // R2 priority: power-up beats power-down
      run_cmd(3'b110, -10);
      check(sd && pll_rst_n && !pll_bypass, "R2", "power-up over power-down", pll_rst_n, 1);

      // R2 empty command and unused select
      run_cmd(3'b000, -10);
      check(!sd && !busy && pll_rst_n, "R2", "empty command ignored", sd, 0);
      wr(2'd3, divword(7, 7, 7));
      run_cmd(3'b001, -10);
      check(sd && t_end == 0, "R2", "select 3 ignored", t_end, 0);
      check_outs("R2");

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule